// File: doc/BRIEF.md
# Open-Switch Fault Detector with Gate Override

This block watches the six legs of a back-to-back two-level converter for an open-circuit switch. On every sample strobe it checks each leg's measured pole voltage against the value implied by that leg's upper-gate command and the DC-link reading. A leg is declared faulty only when two criteria hold together. The first is a voltage criterion: the error exceeds half the DC-link voltage. The second is a time criterion: the error stays that large for a programmable number of consecutive samples. This rejects switching edges and loop delay.

Once a fault is declared, the leg index is latched. Both gates of that leg are forced low in hardware, whatever the controller commands. The bidirectional switch that ties the faulty phase to its twin on the other converter side is turned on. The fault flag and leg index are presented to the supervising controller. All of this state persists until a maintenance clear. Legs 0..2 are phases a, b, c of the first side. Legs 3..5 are phases a, b, c of the second side.

Top module: `ofd_top`

## Requirements
- R1: The estimated pole voltage of a leg is the DC-link value when that leg's upper-gate command is 1 and zero otherwise. The error is the absolute difference between measured and estimated values. A healthy leg whose pole voltage follows its gate never raises a fault.
- R2: On a strobed sample whose error is at or below vdc_i>>1, that leg's consecutive-sample counter returns to zero. An error exactly equal to the threshold does not count.
- R3: On a strobed sample whose error exceeds vdc_i>>1, the counter increments, saturating at CNT_LIMIT. Cycles without sample_valid_i leave it unchanged.
- R4: fault_o goes high at the clock edge of the CNT_LIMIT-th consecutive exceeding sample (default 30) and stays high.
- R5: While fault_o is high, gate_hi_o and gate_lo_o of the faulty leg are 0 in the same cycle. All other gates, and all gates while healthy, equal their commands.
- R6: fault_leg_o gives the faulty leg's index. When several legs qualify on the same edge, the lowest index wins. Detections after the first are ignored.
- R7: While fault_o is high, exactly one bit of reconf_en_o is set. Bit j serves legs j and j+3, so a fault on leg k sets bit k mod 3. While healthy, reconf_en_o is all zero.
- R8: maint_clr_i synchronously clears the fault flag, the leg index and all counters. It takes priority over a detection on the same edge.
- R9: After asynchronous reset, fault_o=0, fault_leg_o=0 and reconf_en_o=0, and gates pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| maint_clr_i | input | 1 | Maintenance clear of fault state |
| sample_valid_i | input | 1 | Strobe marking a new ADC sample |
| vdc_i | input | DATA_W | DC-link voltage sample |
| vpole_i | input | LEGS*DATA_W | Measured pole voltages, leg k at bits [k*DATA_W +: DATA_W] |
| gate_hi_i | input | LEGS | Upper-switch commands |
| gate_lo_i | input | LEGS | Lower-switch commands |
| gate_hi_o | output | LEGS | Upper-switch drive after override |
| gate_lo_o | output | LEGS | Lower-switch drive after override |
| reconf_en_o | output | LEGS/2 | Bidirectional tie-switch enables |
| fault_o | output | 1 | Fault declared |
| fault_leg_o | output | $clog2(LEGS) | Index of the faulty leg |

## Verification
Two events can land on one clock edge. In the first, two legs reach the time criterion together. The bench provokes this by injecting the open switch on legs 3 and 5 in the same sample, and expects leg 3 to be latched with tie switch 0. In the second, a maintenance clear arrives on the edge where a leg completes its count. That edge is judged by fault_o remaining low afterwards, and by a later full count being needed before the fault reappears. A behavioural reference model tracks counters and latch state and is compared with every output after each edge.

// File: rtl/ofd_pkg.sv
package ofd_pkg;
  localparam int unsigned LEGS_DEF      = 6;
  localparam int unsigned DATA_W_DEF    = 12;
  localparam int unsigned CNT_LIMIT_DEF = 30;
endpackage

// File: rtl/ofd_leg_monitor.sv
module ofd_leg_monitor #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CNT_LIMIT = 30,
  localparam int unsigned CNT_W    = $clog2(CNT_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] vdc_i,
  input  logic [DATA_W-1:0] vpole_i,
  input  logic              gate_hi_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] est, err;
  logic              over;
  logic [CNT_W-1:0]  cnt_q;

  assign est  = gate_hi_i ? vdc_i : '0;
  assign err  = (vpole_i >= est) ? (vpole_i - est) : (est - vpole_i);
  assign over = err > (vdc_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (sample_i) begin
      if (!over)                            cnt_q <= '0;
      else if (cnt_q != CNT_W'(CNT_LIMIT))  cnt_q <= cnt_q + 1'b1;
    end
  end

  // one pulse as the count crosses into the limit
  assign hit_o = sample_i && over && (cnt_q == CNT_W'(CNT_LIMIT - 1));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_LIMIT));
  // R2
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !over) |=> (cnt_q == '0));
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ofd_fault_latch.sv
module ofd_fault_latch #(
  parameter int unsigned LEGS  = 6,
  localparam int unsigned IDX_W = $clog2(LEGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LEGS-1:0]  hit_i,
  output logic             fault_o,
  output logic [IDX_W-1:0] leg_o
);
  logic [IDX_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = LEGS - 1; i >= 0; i--)
      if (hit_i[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      leg_o   <= '0;
    end else if (clr_i) begin
      fault_o <= 1'b0;
      leg_o   <= '0;
    end else if (!fault_o && |hit_i) begin
      fault_o <= 1'b1;
      leg_o   <= pick;
    end
  end

  // R4
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(|hit_i));
  // R6
  leg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i) |=> (fault_o && $stable(leg_o)));
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fault_o);
endmodule

// File: rtl/ofd_gate_mask.sv
module ofd_gate_mask #(
  parameter int unsigned LEGS  = 6,
  localparam int unsigned HALF  = LEGS / 2,
  localparam int unsigned IDX_W = $clog2(LEGS)
) (
  input  logic             fault_i,
  input  logic [IDX_W-1:0] leg_i,
  input  logic [LEGS-1:0]  gate_hi_i,
  input  logic [LEGS-1:0]  gate_lo_i,
  output logic [LEGS-1:0]  gate_hi_o,
  output logic [LEGS-1:0]  gate_lo_o,
  output logic [HALF-1:0]  reconf_o
);
  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    logic kill;
    assign kill         = fault_i && (leg_i == IDX_W'(i));
    assign gate_hi_o[i] = gate_hi_i[i] && !kill;
    assign gate_lo_o[i] = gate_lo_i[i] && !kill;
  end

  for (genvar j = 0; j < HALF; j++) begin : g_tie
    assign reconf_o[j] = fault_i &&
      ((leg_i == IDX_W'(j)) || (leg_i == IDX_W'(j + HALF)));
  end
endmodule

// File: rtl/ofd_top.sv
module ofd_top
  import ofd_pkg::*;
#(
  parameter int unsigned LEGS      = LEGS_DEF,
  parameter int unsigned DATA_W    = DATA_W_DEF,
  parameter int unsigned CNT_LIMIT = CNT_LIMIT_DEF,
  localparam int unsigned HALF     = LEGS / 2,
  localparam int unsigned IDX_W    = $clog2(LEGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   maint_clr_i,
  input  logic                   sample_valid_i,
  input  logic [DATA_W-1:0]      vdc_i,
  input  logic [LEGS*DATA_W-1:0] vpole_i,
  input  logic [LEGS-1:0]        gate_hi_i,
  input  logic [LEGS-1:0]        gate_lo_i,
  output logic [LEGS-1:0]        gate_hi_o,
  output logic [LEGS-1:0]        gate_lo_o,
  output logic [HALF-1:0]        reconf_en_o,
  output logic                   fault_o,
  output logic [IDX_W-1:0]       fault_leg_o
);
  logic [LEGS-1:0] hit;

  for (genvar k = 0; k < LEGS; k++) begin : g_mon
    ofd_leg_monitor #(.DATA_W(DATA_W), .CNT_LIMIT(CNT_LIMIT)) u_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (maint_clr_i),
      .sample_i  (sample_valid_i),
      .vdc_i     (vdc_i),
      .vpole_i   (vpole_i[k*DATA_W +: DATA_W]),
      .gate_hi_i (gate_hi_i[k]),
      .hit_o     (hit[k])
    );
  end

  ofd_fault_latch #(.LEGS(LEGS)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (maint_clr_i),
    .hit_i   (hit),
    .fault_o (fault_o),
    .leg_o   (fault_leg_o)
  );

  ofd_gate_mask #(.LEGS(LEGS)) u_mask (
    .fault_i   (fault_o),
    .leg_i     (fault_leg_o),
    .gate_hi_i (gate_hi_i),
    .gate_lo_i (gate_lo_i),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o),
    .reconf_o  (reconf_en_o)
  );

  // R5
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(gate_hi_o[fault_leg_o] || gate_lo_o[fault_leg_o]));
  // R7
  tie_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($countones(reconf_en_o) == 1));
  // R7
  tie_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (reconf_en_o == '0));
  // R5
  gate_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> ((gate_hi_o == gate_hi_i) && (gate_lo_o == gate_lo_i)));
endmodule

// File: tb/ofd_top_test.sv
module ofd_top_test;
  localparam int LEGS = 6;
  localparam int W    = 12;
  localparam int N    = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, valid = 1'b0;
  logic [W-1:0] vdc = 12'd2000;
  logic [W-1:0] vp [LEGS];
  logic [LEGS*W-1:0] vpole;
  logic [LEGS-1:0] ghi = '0, glo = '0, gho, glo_o;
  logic [2:0] reconf;
  logic fault;
  logic [2:0] fleg;

  int checks = 0, errors = 0, k = 0;
  int mcnt [LEGS];
  bit mf = 0;
  int mleg = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < LEGS; i++) vpole[i*W +: W] = vp[i];

  ofd_top uut (
    .clk_i(clk), .rst_ni(rst_n), .maint_clr_i(clr), .sample_valid_i(valid),
    .vdc_i(vdc), .vpole_i(vpole), .gate_hi_i(ghi), .gate_lo_i(glo),
    .gate_hi_o(gho), .gate_lo_o(glo_o), .reconf_en_o(reconf),
    .fault_o(fault), .fault_leg_o(fleg)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    int first, est, e;
    if (!rst_n) begin
      for (int i = 0; i < LEGS; i++) mcnt[i] = 0;
      mf = 0; mleg = 0;
    end else if (clr) begin
      for (int i = 0; i < LEGS; i++) mcnt[i] = 0;
      mf = 0; mleg = 0;
    end else if (valid) begin
      first = -1;
      for (int i = 0; i < LEGS; i++) begin
        est = ghi[i] ? int'(vdc) : 0;
        e = int'(vp[i]) - est;
        if (e < 0) e = -e;
        if (e > int'(vdc) / 2) begin
          if (mcnt[i] == N - 1 && first < 0) first = i;
          if (mcnt[i] < N) mcnt[i]++;
        end else mcnt[i] = 0;
      end
      if (!mf && first >= 0) begin mf = 1; mleg = first; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [LEGS-1:0] eh, el;
    logic [2:0] er;
    eh = ghi; el = glo; er = '0;
    if (mf) begin
      eh[mleg] = 1'b0; el[mleg] = 1'b0;
      er[mleg % 3] = 1'b1;
    end
    chk("R4 fault_o", int'(fault), int'(mf));
    chk("R6 fault_leg_o", int'(fleg), mleg);
    chk("R5 gate_hi_o", int'(gho), int'(eh));
    chk("R5 gate_lo_o", int'(glo_o), int'(el));
    chk("R7 reconf_en_o", int'(reconf), int'(er));
  endtask

  // bad: legs with open upper switch; thr>=0 forces leg 0 to gate low with pole = thr
  task automatic step(input logic [LEGS-1:0] bad, input logic v, input logic c,
                      input int thr);
    for (int i = 0; i < LEGS; i++) begin
      ghi[i] = ((k >> (i % 3)) & 1) != 0;
      if (bad[i]) ghi[i] = 1'b1;
      glo[i] = ~ghi[i];
      vp[i]  = bad[i] ? '0 : (ghi[i] ? vdc : '0);
    end
    if (thr >= 0) begin ghi[0] = 1'b0; glo[0] = 1'b1; vp[0] = W'(thr); end
    valid = v; clr = c; k++;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LEGS; i++) vp[i] = '0;
    ghi = 6'b101010; glo = 6'b010101;
    #45;
    // R9 reset state
    chk("R9 fault after reset", int'(fault), 0);
    chk("R9 leg after reset", int'(fleg), 0);
    chk("R9 reconf after reset", int'(reconf), 0);
    chk("R9 gates pass in reset", int'(gho), int'(6'b101010));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 healthy toggling with two DC-link levels
    for (int c = 0; c < 120; c++) step('0, 1'b1, 1'b0, -1);
    vdc = 12'd900;
    for (int c = 0; c < 60; c++) step('0, 1'b1, 1'b0, -1);
    chk("R1 healthy no fault", int'(fault), 0);
    vdc = 12'd2000;

    // R2 error equal to threshold never counts
    for (int c = 0; c < N + 10; c++) step('0, 1'b1, 1'b0, 1000);
    chk("R2 error at threshold", int'(fault), 0);

    // R2 runs of N-1 exceeding samples broken by a clean one
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < N - 1; c++) step('0, 1'b1, 1'b0, 1001);
      step('0, 1'b1, 1'b0, -1);
    end
    chk("R2 broken runs", int'(fault), 0);

    // R3 counting holds across missing strobes
    for (int c = 0; c < 20; c++) step(6'b000100, 1'b1, 1'b0, -1);
    for (int c = 0; c < 10; c++) step(6'b000100, 1'b0, 1'b0, -1);
    for (int c = 0; c < 9; c++) step(6'b000100, 1'b1, 1'b0, -1);
    chk("R3 one sample short", int'(fault), 0);
    step(6'b000100, 1'b1, 1'b0, -1);
    chk("R4 fault at limit", int'(fault), 1);
    chk("R6 leg two", int'(fleg), 2);
    chk("R7 tie two", int'(reconf), 4);
    chk("R5 leg two upper forced", int'(gho[2]), 0);

    // R6 later detection ignored
    for (int c = 0; c < N + 5; c++) step(6'b000110, 1'b1, 1'b0, -1);
    chk("R6 later leg ignored", int'(fleg), 2);

    // R8 maintenance clear
    step('0, 1'b1, 1'b1, -1);
    chk("R8 cleared", int'(fault), 0);

    // R6 simultaneous legs 3 and 5
    for (int c = 0; c < N; c++) step(6'b101000, 1'b1, 1'b0, -1);
    chk("R6 lowest leg wins", int'(fleg), 3);
    chk("R7 tie zero for leg three", int'(reconf), 1);
    step('0, 1'b1, 1'b1, -1);

    // R8 clear on the detecting edge
    for (int c = 0; c < N - 1; c++) step(6'b010000, 1'b1, 1'b0, -1);
    step(6'b010000, 1'b1, 1'b1, -1);
    chk("R8 clear beats detection", int'(fault), 0);
    for (int c = 0; c < N - 1; c++) step(6'b010000, 1'b1, 1'b0, -1);
    chk("R8 counters restarted", int'(fault), 0);
    step(6'b010000, 1'b1, 1'b0, -1);
    chk("R7 tie one for leg four", int'(reconf), 2);
    for (int c = 0; c < 10; c++) step('0, 1'b1, 1'b0, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule